// File: doc/BRIEF.md
# Switch and LED Register Slave on AXI4-Lite

This block connects a processor bus to a small piece of board I/O. It is an AXI4-Lite slave with two 32-bit words. One word gives the processor a read-only view of an 8-bit bank of switches. The other is a read/write word, and its least significant byte drives an 8-bit LED output without pause. The remaining two word slots in the 16-byte window are reserved. They read as zero and ignore writes.

All five channels are implemented on one clock with a synchronous active-low reset: write address, write data, write response, read address and read data. The write address and write data may arrive in either order or in the same cycle, and the write commits only when both have been taken. Each byte strobe guards its own byte lane. The switch input passes through a two-stage synchronizer before it reaches the read mux. The protection inputs are accepted and have no effect.

Top module: `board_io_axil`

## Requirements
- R1: While rst_n is low, every valid and ready output (awready, wready, bvalid, arready, rvalid) is 0 and led_out is 0. The stored LED word resets to 0.
- R2: A read whose address bits 3:2 equal 0 (offset 0x0) returns the synchronized switch value in bits 7:0 and zeros in bits 31:8.
- R3: A write to offset 0x4 updates byte lane k (bits 8k+7:8k) of the LED word only where wstrb[k] is 1. led_out always equals bits 7:0 of that word.
- R4: A read of offset 0x4 returns all 32 bits of the LED word.
- R5: Writes to offsets 0x0, 0x8 and 0xC change no state, and reads of 0x8 and 0xC return 0. Both still respond OKAY (code 2'b00). Address bits 1:0 are not decoded.
- R6: A write commits after both the AW and the W handshake, in either order or in the same cycle. bvalid is then 1 with bresp 2'b00 and stays 1 until bready. awready and wready stay 0 while a response is pending.
- R7: After an AR handshake, rvalid rises on the next clock edge with rresp 2'b00. rdata stays stable and rvalid stays high until rready. arready stays 0 while a read response is pending.
- R8: A switch change is captured by a read only when the AR handshake occurs on the third rising edge after the change or later. A handshake on the first edge after the change returns the previous value.
- R9: awprot and arprot have no effect on data, responses or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | 4 | Write address (byte) |
| awprot | input | 3 | Write protection attributes, unused |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte lane enables for write data |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted by master |
| araddr | input | 4 | Read address (byte) |
| arprot | input | 3 | Read protection attributes, unused |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted by master |
| sw_in | input | 8 | Asynchronous switch inputs |
| led_out | output | 8 | LED drive |

## Verification
The stability properties assume the master obeys the handshake rules. Once a valid is raised, it stays raised until the matching ready is seen, and the master never withdraws a pending response acceptance mid-cycle. The bench drives every input only on falling edges and holds each valid until it has seen ready at a falling edge. It holds bready and rready low for a chosen number of cycles, so the hold properties are exercised over real stall windows. The switch bus is changed only on falling edges, which gives the synchronizer the clean single-edge sampling its latency requirement relies on.

// File: rtl/board_io_pkg.sv
package board_io_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axi_resp_e;

  localparam logic [1:0] SLOT_SWITCH = 2'd0;
  localparam logic [1:0] SLOT_LED    = 2'd1;
endpackage

// File: rtl/io_sync.sv
module io_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[i] <= '0;
      else if (i == 0) stage[i] <= d;
      else stage[i] <= stage[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/axil_wr_chan.sv
module axil_wr_chan #(
  parameter int SEL_W  = 2,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic [SEL_W-1:0]  aw_sel,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              fire,
  output logic [SEL_W-1:0]  fire_sel,
  output logic [DATA_W-1:0] fire_data,
  output logic [STRB_W-1:0] fire_strb
);
  logic              aw_have, w_have, b_pend;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              aw_hs, w_hs;

  assign awready = live & ~aw_have & ~b_pend;
  assign wready  = live & ~w_have & ~b_pend;
  assign aw_hs   = awvalid & awready;
  assign w_hs    = wvalid & wready;
  assign fire    = (aw_have | aw_hs) & (w_have | w_hs);

  assign fire_sel  = aw_have ? sel_q  : aw_sel;
  assign fire_data = w_have  ? data_q : wdata;
  assign fire_strb = w_have  ? strb_q : wstrb;
  assign bvalid    = b_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_have <= 1'b0;
      w_have  <= 1'b0;
      b_pend  <= 1'b0;
      sel_q   <= '0;
      data_q  <= '0;
      strb_q  <= '0;
    end else begin
      if (b_pend && bready) b_pend <= 1'b0;
      if (fire) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
        b_pend  <= 1'b1;
      end else begin
        if (aw_hs) aw_have <= 1'b1;
        if (w_hs)  w_have  <= 1'b1;
      end
      if (aw_hs) sel_q <= aw_sel;
      if (w_hs) begin
        data_q <= wdata;
        strb_q <= wstrb;
      end
    end
  end
endmodule

// File: rtl/axil_rd_chan.sv
module axil_rd_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              arvalid,
  output logic              arready,
  input  logic [DATA_W-1:0] word_in,
  output logic              take,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  input  logic              rready
);
  logic              r_pend;
  logic [DATA_W-1:0] r_word;

  assign arready = live & ~r_pend;
  assign take    = arvalid & arready;
  assign rvalid  = r_pend;
  assign rdata   = r_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_pend <= 1'b0;
      r_word <= '0;
    end else begin
      if (r_pend && rready) r_pend <= 1'b0;
      if (take) begin
        r_pend <= 1'b1;
        r_word <= word_in;
      end
    end
  end
endmodule

// File: rtl/board_io_axil.sv
module board_io_axil
  import board_io_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int IO_W        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int STRB_W  = DATA_W / 8,
  localparam int SEL_LSB = $clog2(STRB_W),
  localparam int SEL_W   = ADDR_W - SEL_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [2:0]        awprot,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [2:0]        arprot,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [IO_W-1:0]   sw_in,
  output logic [IO_W-1:0]   led_out
);
  function automatic logic [DATA_W-1:0] merge_lanes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [STRB_W-1:0] en);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int k = 0; k < STRB_W; k++)
      if (en[k]) res[8*k +: 8] = new_w[8*k +: 8];
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] pick_word(
    input logic [SEL_W-1:0]  sel,
    input logic [IO_W-1:0]   sw,
    input logic [DATA_W-1:0] led_w);
    logic [DATA_W-1:0] res;
    res = '0;
    if (sel == SEL_W'(SLOT_SWITCH))   res[IO_W-1:0] = sw;
    else if (sel == SEL_W'(SLOT_LED)) res = led_w;
    return res;
  endfunction

  logic              live;
  logic [IO_W-1:0]   sw_sync;
  logic [DATA_W-1:0] led_word;
  logic              wr_fire;
  logic [SEL_W-1:0]  wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              rd_take;
  logic [DATA_W-1:0] rd_word;
  logic              led_hit;
  logic              unused_inputs;

  assign unused_inputs = ^{awprot, arprot, awaddr[SEL_LSB-1:0], araddr[SEL_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  io_sync #(.W(IO_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_in), .q(sw_sync));

  axil_wr_chan #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .live(live),
    .aw_sel(awaddr[ADDR_W-1:SEL_LSB]), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bvalid(bvalid), .bready(bready),
    .fire(wr_fire), .fire_sel(wr_sel), .fire_data(wr_data), .fire_strb(wr_strb));

  assign led_hit = wr_fire && (wr_sel == SEL_W'(SLOT_LED));

  always_ff @(posedge clk) begin
    if (!rst_n)       led_word <= '0;
    else if (led_hit) led_word <= merge_lanes(led_word, wr_data, wr_strb);
  end

  assign rd_word = pick_word(araddr[ADDR_W-1:SEL_LSB], sw_sync, led_word);

  axil_rd_chan #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .live(live),
    .arvalid(arvalid), .arready(arready), .word_in(rd_word), .take(rd_take),
    .rvalid(rvalid), .rdata(rdata), .rready(rready));

  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;
  assign led_out = led_word[IO_W-1:0];
endmodule

// File: rtl/board_io_axil_chk.sv
module board_io_axil_chk #(
  parameter int DATA_W = 32,
  parameter int IO_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awready,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic              arready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_take,
  input logic              wr_fire,
  input logic [IO_W-1:0]   led_out
);
  p_bvalid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  p_no_accept_while_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready && !wready);
  p_fire_raises_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bvalid);
  p_rvalid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  p_no_ar_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);
  p_take_raises_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rvalid);
  p_led_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(led_out));
endmodule

bind board_io_axil board_io_axil_chk #(.DATA_W(DATA_W), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .awready(awready), .wready(wready),
  .bvalid(bvalid), .bready(bready), .arready(arready), .rvalid(rvalid),
  .rready(rready), .rdata(rdata), .rd_take(rd_take), .wr_fire(wr_fire),
  .led_out(led_out));

// File: tb/sim_board_io_axil.sv
`timescale 1ns/1ps
module sim_board_io_axil;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic [2:0]  awprot = '0, arprot = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
  logic        arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [7:0]  sw_in = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [7:0]  led_out;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [31:0] led_model = '0;
  logic [7:0]  sw_seen = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  board_io_axil u0 (
    .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid),
    .awready(awready), .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready), .araddr(araddr), .arprot(arprot),
    .arvalid(arvalid), .arready(arready), .rdata(rdata), .rresp(rresp), .rvalid(rvalid),
    .rready(rready), .sw_in(sw_in), .led_out(led_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] lane_merge(input logic [31:0] o, input logic [31:0] n,
                                             input logic [3:0] s);
    logic [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (n & m) | (o & ~m);
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input int hold);
    logic a_done, w_done, a_now, w_now;
    a_done = 1'b0; w_done = 1'b0;
    awaddr = a; wdata = d; wstrb = s; awprot = 3'(order + hold);
    if (order != 2) awvalid = 1'b1;
    if (order != 1) wvalid = 1'b1;
    while (!(a_done && w_done)) begin
      a_now = awvalid && awready;
      w_now = wvalid && wready;
      @(negedge clk);
      if (a_now) begin
        awvalid = 1'b0; a_done = 1'b1;
        if (order == 1 && !w_done) wvalid = 1'b1;
      end
      if (w_now) begin
        wvalid = 1'b0; w_done = 1'b1;
        if (order == 2 && !a_done) awvalid = 1'b1;
      end
    end
    if (a == 4'h4 || a == 4'h5 || a == 4'h6 || a == 4'h7) led_model = lane_merge(led_model, d, s);
    check("R6 bvalid after both handshakes", {31'd0, bvalid}, 32'd1);
    check("R6 bresp OKAY", {30'd0, bresp}, 32'd0);
    check("R6 awready/wready low while pending", {30'd0, awready, wready}, 32'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R6 bvalid held until bready", {31'd0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    check("R6 bvalid cleared after bready", {31'd0, bvalid}, 32'd0);
    check("R3 led_out mirrors low byte", {24'd0, led_out}, {24'd0, led_model[7:0]});
  endtask

  task automatic do_read(input logic [3:0] a, input int hold, output logic [31:0] got);
    araddr = a; arprot = 3'(hold); arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    check("R7 rvalid after AR handshake", {31'd0, rvalid}, 32'd1);
    check("R7 rresp OKAY", {30'd0, rresp}, 32'd0);
    check("R7 arready low while pending", {31'd0, arready}, 32'd0);
    got = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R7 rdata stable until rready", rdata, got);
    end
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    check("R7 rvalid cleared after rready", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] got;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {22'd0, awready, wready, bvalid, arready, rvalid, led_out},
          32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      sw_in = 8'(v * 37 + 5);
      repeat (3) @(negedge clk);
      do_read(4'h0 | 4'(v % 4), v % 3, got);
      check("R2 switch word", got, {24'd0, sw_in});
    end

    sw_seen = sw_in;
    sw_in = ~sw_seen;
    do_read(4'h0, 0, got);
    check("R8 first-edge read returns old switch value", got, {24'd0, sw_seen});
    repeat (3) @(negedge clk);
    do_read(4'h0, 1, got);
    check("R8 synchronized switch value", got, {24'd0, ~sw_seen});

    for (int s = 0; s < 16; s++) begin
      do_write(4'h4, 32'h1000_0001 * (s + 3) ^ 32'hA5C3_5A3C, 4'(s), s % 3, s % 4);
      do_read(4'h4, s % 2, got);
      check("R4 LED word readback with strobes R3", got, led_model);
    end

    for (int k = 0; k < 3; k++) begin
      do_write(k == 0 ? 4'h0 : (k == 1 ? 4'h8 : 4'hC), 32'hFFFF_FFFF, 4'hF, k, 1);
      do_read(4'h4, 0, got);
      check("R5 ignored write leaves LED word", got, led_model);
    end
    do_read(4'h8, 1, got);
    check("R5 spare word 0x8 reads zero", got, 32'd0);
    do_read(4'hC, 2, got);
    check("R5 spare word 0xC reads zero", got, 32'd0);

    for (int p = 0; p < 8; p++) begin
      do_write(4'h4, {4{8'(p * 29)}}, 4'hF, p % 3, 0);
      do_read(4'h4, 0, got);
      check("R9 prot has no effect", got, {4{8'(p * 29)}});
    end

    rst_n = 1'b0;
    @(negedge clk);
    led_model = '0;
    check("R1 reset clears LED and handshakes",
          {22'd0, awready, wready, bvalid, arready, rvalid, led_out}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(4'h4, 0, got);
    check("R1 LED word zero after reset", got, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule